// File: doc/BRIEF.md
# Resistive Touch Panel Scan Sequencer

This block measures a resistive touch panel over and over while its automatic mode is on. Each measurement covers one X/Y pair and runs a fixed chain of timed steps:

1. A settle interval.
2. An X conversion.
3. A second settle interval.
4. A Y conversion.
5. An inter-sample gap.
6. A touch-detect window, in which the pen comparator is sampled.
7. An idle interval.

Every timed step lasts a programmed number of clock cycles. During each conversion the block drives the matching panel axis. It talks to an external converter through a one-cycle start pulse and a done pulse that carries a 10-bit result.

At the end of each pair, one 32-bit word goes into a small sample FIFO:

- bit 31 holds the pen level (1 means pen up);
- bits 25:16 hold the X result;
- bits 9:0 hold the Y result.

Software reaches the block through a simple register port. It sets the control bits and the step durations, polls the status, and pops samples. A level interrupt asks for service once the FIFO holds enough words.

When a conversion is configured for fewer than 10 bits, the converter returns the result in the low bits. The block shifts it up so that it fills the top of the 10-bit field.

Top module: `tsq_scan_ctrl`

## Requirements
- R1: After reset the register port reads:
  - control (address 0): 0;
  - status (address 1): 0x80, meaning empty;
  - settle (address 3): 2;
  - start delay (address 4): 2;
  - gap (address 5): 4;
  - touch (address 6): 16;
  - idle (address 7): 88.
- R2: Each pair runs its steps in this order: settle, X conversion with drive_x high, settle, Y conversion with drive_y high, gap, touch-detect with touch_sense high for exactly the touch value in cycles, then idle. With a converter latency of L cycles, successive X conversions start 2*settle + 2*L + gap + touch + idle cycles apart.
- R3: Each conversion begins with adc_start high for exactly one cycle. The conversion step ends in the cycle in which adc_done is sampled high.
- R4: The pushed word carries the inverted pen_down level at bit 31 (1 = pen up), X at bits 25:16 and Y at bits 9:0. Every other bit is 0. The pen level is the one seen in the last touch-detect cycle.
- R5: The control fields at bits 9:7 (X) and 6:4 (Y) each hold s = 10 minus the resolution. The stored result is the converter value shifted left by s and cut to 10 bits.
- R6: A register read of address 2 returns the oldest word and pops it. Words come out in push order. Status bit 7 is 1 exactly when the FIFO is empty.
- R7: The FIFO holds 4 words. A push into a full FIFO is dropped and sets status bit 8. Bit 8 stays set until a pop empties the FIFO.
- R8: irq is high exactly while the FIFO holds 4 or more words.
- R9: After control bit 0 (auto) is written to 1, the first X conversion starts start-delay + settle cycles after the cycle that follows the write.
- R10: When auto is written to 0, the block finishes the current step and then stops. If that step is touch-detect, its word is still pushed. After that no adc_start occurs and drive_x, drive_y and touch_sense stay low.
- R11: Control bit 2 (power) reads back as written and drives adc_power.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO at address 2) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq | output | 1 | FIFO level interrupt |
| adc_power | output | 1 | Converter power request |
| adc_start | output | 1 | One-cycle conversion start |
| adc_done | input | 1 | Conversion finished, adc_data valid |
| adc_data | input | 10 | Conversion result, right-aligned |
| drive_x | output | 1 | Drive the X axis of the panel |
| drive_y | output | 1 | Drive the Y axis of the panel |
| touch_sense | output | 1 | Touch-detect window active |
| pen_down | input | 1 | Pen comparator, 1 when touched |

## Verification
The scan chain is exercised in several ways:

- **Default durations with a fixed converter latency.** This pins the exact pair period and the touch window width.
- **Randomised durations, latencies, resolutions and pen levels.** These show whether each step is timed from its own register and whether words are packed and aligned correctly.
- **Runs of five and six pairs without service.** These separate drop-on-full from overwrite behaviour, and show that the sticky overrun flag is released only by draining.
- **Auto cleared in the touch window versus in the idle step.** This shows the current step being completed rather than cut short.
- **A start measured with non-default delays.** This checks the start-up latency.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
    localparam int SMP_W   = 10;
    localparam int TIME_W  = 8;
    localparam int REG_W   = 32;
    localparam int ADDR_W  = 3;
    localparam int SHIFT_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT   = 3'd1;
    localparam logic [ADDR_W-1:0] A_FIFO   = 3'd2;
    localparam logic [ADDR_W-1:0] A_SETTLE = 3'd3;
    localparam logic [ADDR_W-1:0] A_START  = 3'd4;
    localparam logic [ADDR_W-1:0] A_GAP    = 3'd5;
    localparam logic [ADDR_W-1:0] A_TOUCH  = 3'd6;
    localparam logic [ADDR_W-1:0] A_IDLE   = 3'd7;

    localparam int CTRL_AUTO  = 0;
    localparam int CTRL_PWR   = 2;
    localparam int CTRL_YS_LO = 4;
    localparam int CTRL_XS_LO = 7;
    localparam int STAT_EMPTY = 7;
    localparam int STAT_OVR   = 8;
    localparam int WORD_Y_LO  = 0;
    localparam int WORD_X_LO  = 16;
    localparam int WORD_PEN   = 31;

    localparam logic [TIME_W-1:0] RST_SETTLE = 8'd2;
    localparam logic [TIME_W-1:0] RST_START  = 8'd2;
    localparam logic [TIME_W-1:0] RST_GAP    = 8'd4;
    localparam logic [TIME_W-1:0] RST_TOUCH  = 8'd16;
    localparam logic [TIME_W-1:0] RST_IDLE   = 8'd88;

    typedef struct packed {
        logic [TIME_W-1:0] settle;
        logic [TIME_W-1:0] start_dly;
        logic [TIME_W-1:0] gap;
        logic [TIME_W-1:0] touch;
        logic [TIME_W-1:0] idle;
    } timing_t;

    typedef enum logic [3:0] {
        PH_OFF, PH_START, PH_SET_X, PH_CNV_X, PH_SET_Y,
        PH_CNV_Y, PH_GAP, PH_TOUCH, PH_IDLE
    } phase_e;
endpackage

// File: rtl/tsq_regs.sv
module tsq_regs
    import tsq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [REG_W-1:0]   wdata,
    input  logic [REG_W-1:0]   fifo_head,
    input  logic               fifo_empty,
    input  logic               fifo_ovr,
    output logic [REG_W-1:0]   rdata,
    output logic               auto_en,
    output logic               power,
    output logic [SHIFT_W-1:0] xshift,
    output logic [SHIFT_W-1:0] yshift,
    output timing_t            timing
);
    typedef struct packed {
        logic               auto_en;
        logic               power;
        logic [SHIFT_W-1:0] xs;
        logic [SHIFT_W-1:0] ys;
        timing_t            tm;
    } regs_t;

    regs_t q, d;
    logic  unused_wdata;

    assign unused_wdata = &{1'b0, wdata[REG_W-1:SMP_W]};

    always_comb begin
        d = q;
        if (wr) begin
            case (addr)
                A_CTRL: begin
                    d.auto_en = wdata[CTRL_AUTO];
                    d.power   = wdata[CTRL_PWR];
                    d.xs      = wdata[CTRL_XS_LO +: SHIFT_W];
                    d.ys      = wdata[CTRL_YS_LO +: SHIFT_W];
                end
                A_SETTLE: d.tm.settle    = wdata[TIME_W-1:0];
                A_START:  d.tm.start_dly = wdata[TIME_W-1:0];
                A_GAP:    d.tm.gap       = wdata[TIME_W-1:0];
                A_TOUCH:  d.tm.touch     = wdata[TIME_W-1:0];
                A_IDLE:   d.tm.idle      = wdata[TIME_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[CTRL_AUTO]               = q.auto_en;
                rdata[CTRL_PWR]                = q.power;
                rdata[CTRL_XS_LO +: SHIFT_W]   = q.xs;
                rdata[CTRL_YS_LO +: SHIFT_W]   = q.ys;
            end
            A_STAT: begin
                rdata[STAT_OVR]   = fifo_ovr;
                rdata[STAT_EMPTY] = fifo_empty;
            end
            A_FIFO:   rdata = fifo_empty ? '0 : fifo_head;
            A_SETTLE: rdata[TIME_W-1:0] = q.tm.settle;
            A_START:  rdata[TIME_W-1:0] = q.tm.start_dly;
            A_GAP:    rdata[TIME_W-1:0] = q.tm.gap;
            A_TOUCH:  rdata[TIME_W-1:0] = q.tm.touch;
            A_IDLE:   rdata[TIME_W-1:0] = q.tm.idle;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.auto_en <= 1'b0;
            q.power   <= 1'b0;
            q.xs      <= '0;
            q.ys      <= '0;
            q.tm      <= '{settle: RST_SETTLE, start_dly: RST_START,
                           gap: RST_GAP, touch: RST_TOUCH, idle: RST_IDLE};
        end else begin
            q <= d;
        end
    end

    assign auto_en = q.auto_en;
    assign power   = q.power;
    assign xshift  = q.xs;
    assign yshift  = q.ys;
    assign timing  = q.tm;

    // R2
    settle_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_SETTLE) |=> (timing.settle == $past(wdata[TIME_W-1:0])));

    // R11
    power_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_CTRL) |=> (power == $past(wdata[CTRL_PWR])));
endmodule

// File: rtl/tsq_seq.sv
module tsq_seq
    import tsq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               auto_en,
    input  timing_t            timing,
    input  logic [SHIFT_W-1:0] xshift,
    input  logic [SHIFT_W-1:0] yshift,
    input  logic               adc_done,
    input  logic [SMP_W-1:0]   adc_data,
    input  logic               pen_down,
    output logic               adc_start,
    output logic               drive_x,
    output logic               drive_y,
    output logic               touch_sense,
    output logic               push,
    output logic [REG_W-1:0]   push_word
);
    typedef struct packed {
        phase_e            ph;
        logic [TIME_W-1:0] cnt;
        logic              started;
        logic [SMP_W-1:0]  xv;
        logic [SMP_W-1:0]  yv;
    } seq_t;

    seq_t   q, d;
    logic   go;
    logic   tdone;
    phase_e nxt;

    function automatic logic [TIME_W-1:0] dur(input phase_e p, input timing_t t);
        case (p)
            PH_START:           dur = t.start_dly;
            PH_SET_X, PH_SET_Y: dur = t.settle;
            PH_GAP:             dur = t.gap;
            PH_TOUCH:           dur = t.touch;
            PH_IDLE:            dur = t.idle;
            default:            dur = '0;
        endcase
    endfunction

    function automatic logic [SMP_W-1:0] align(input logic [SMP_W-1:0] v,
                                               input logic [SHIFT_W-1:0] sh);
        align = v << sh;
    endfunction

    always_comb begin
        d         = q;
        go        = 1'b0;
        nxt       = PH_OFF;
        push      = 1'b0;
        push_word = '0;
        tdone     = (q.cnt <= 1);
        push_word[WORD_PEN]            = ~pen_down;
        push_word[WORD_X_LO +: SMP_W]  = q.xv;
        push_word[WORD_Y_LO +: SMP_W]  = q.yv;
        case (q.ph)
            PH_OFF: begin
                go  = auto_en;
                nxt = PH_START;
            end
            PH_START: begin
                go  = tdone;
                nxt = PH_SET_X;
            end
            PH_SET_X: begin
                go  = tdone;
                nxt = PH_CNV_X;
            end
            PH_CNV_X: begin
                d.started = 1'b1;
                nxt       = PH_SET_Y;
                if (adc_done) begin
                    d.xv = align(adc_data, xshift);
                    go   = 1'b1;
                end
            end
            PH_SET_Y: begin
                go  = tdone;
                nxt = PH_CNV_Y;
            end
            PH_CNV_Y: begin
                d.started = 1'b1;
                nxt       = PH_GAP;
                if (adc_done) begin
                    d.yv = align(adc_data, yshift);
                    go   = 1'b1;
                end
            end
            PH_GAP: begin
                go  = tdone;
                nxt = PH_TOUCH;
            end
            PH_TOUCH: begin
                go   = tdone;
                nxt  = PH_IDLE;
                push = tdone;
            end
            PH_IDLE: begin
                go  = tdone;
                nxt = PH_SET_X;
            end
            default: begin
                go  = 1'b1;
                nxt = PH_OFF;
            end
        endcase
        if (go) begin
            d.ph      = auto_en ? nxt : PH_OFF;
            d.cnt     = dur(d.ph, timing);
            d.started = 1'b0;
        end else if (q.cnt != 0) begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.ph      <= PH_OFF;
            q.cnt     <= '0;
            q.started <= 1'b0;
            q.xv      <= '0;
            q.yv      <= '0;
        end else begin
            q <= d;
        end
    end

    assign adc_start   = (q.ph == PH_CNV_X || q.ph == PH_CNV_Y) && !q.started;
    assign drive_x     = (q.ph == PH_SET_X || q.ph == PH_CNV_X);
    assign drive_y     = (q.ph == PH_SET_Y || q.ph == PH_CNV_Y);
    assign touch_sense = (q.ph == PH_TOUCH);

    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    // R2
    drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drive_x, drive_y, touch_sense}));

    // R3
    x_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_CNV_X && adc_done) |=> (q.ph == PH_SET_Y || q.ph == PH_OFF));

    // R10
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_OFF && !auto_en) |=> (q.ph == PH_OFF && !adc_start));
endmodule

// File: rtl/tsq_fifo.sv
module tsq_fifo #(
    parameter int DEPTH  = 4,
    parameter int THRESH = 4,
    parameter int W      = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         ovr,
    output logic         irq
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rp;
        logic [PW-1:0]           wp;
        logic [CW-1:0]           cnt;
        logic                    ovr;
    } fifo_t;

    fifo_t q, d;
    logic  full;
    logic  do_pop;
    logic  do_push;

    function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
        inc = (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d       = q;
        full    = (q.cnt == CW'(DEPTH));
        do_pop  = pop && (q.cnt != 0);
        do_push = push && (!full || do_pop);
        if (push && !do_push) begin
            d.ovr = 1'b1;
        end
        if (do_push) begin
            d.mem[q.wp] = push_data;
            d.wp        = inc(q.wp);
        end
        if (do_pop) begin
            d.rp = inc(q.rp);
        end
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: ;
        endcase
        if (do_pop && !do_push && q.cnt == 1) begin
            d.ovr = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign head  = q.mem[q.rp];
    assign empty = (q.cnt == 0);
    assign ovr   = q.ovr;
    assign irq   = (q.cnt >= CW'(THRESH));

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));

    // R7
    ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> ($past(push) && $past(q.cnt) == CW'(DEPTH)));

    // R6
    pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !push) |=> (q.cnt == $past(q.cnt) - 1'b1));

    // R8
    irq_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !empty);
endmodule

// File: rtl/tsq_scan_ctrl.sv
module tsq_scan_ctrl
    import tsq_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int IRQ_LEVEL  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq,
    output logic              adc_power,
    output logic              adc_start,
    input  logic              adc_done,
    input  logic [SMP_W-1:0]  adc_data,
    output logic              drive_x,
    output logic              drive_y,
    output logic              touch_sense,
    input  logic              pen_down
);
    logic               auto_en;
    logic [SHIFT_W-1:0] xshift;
    logic [SHIFT_W-1:0] yshift;
    timing_t            timing;
    logic               push;
    logic [REG_W-1:0]   push_word;
    logic [REG_W-1:0]   fifo_head;
    logic               fifo_empty;
    logic               fifo_ovr;
    logic               pop;

    assign pop = reg_rd && (reg_addr == A_FIFO);

    tsq_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .fifo_head  (fifo_head),
        .fifo_empty (fifo_empty),
        .fifo_ovr   (fifo_ovr),
        .rdata      (reg_rdata),
        .auto_en    (auto_en),
        .power      (adc_power),
        .xshift     (xshift),
        .yshift     (yshift),
        .timing     (timing)
    );

    tsq_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .auto_en     (auto_en),
        .timing      (timing),
        .xshift      (xshift),
        .yshift      (yshift),
        .adc_done    (adc_done),
        .adc_data    (adc_data),
        .pen_down    (pen_down),
        .adc_start   (adc_start),
        .drive_x     (drive_x),
        .drive_y     (drive_y),
        .touch_sense (touch_sense),
        .push        (push),
        .push_word   (push_word)
    );

    tsq_fifo #(
        .DEPTH  (FIFO_DEPTH),
        .THRESH (IRQ_LEVEL),
        .W      (REG_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_word),
        .pop       (pop),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .ovr       (fifo_ovr),
        .irq       (irq)
    );
endmodule

// File: tb/tsq_scan_ctrl_test.sv
module tsq_scan_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, adc_power, adc_start, drive_x, drive_y, touch_sense;
    logic        adc_done = 1'b0;
    logic [9:0]  adc_data = '0;
    logic        pen_down = 1'b0;

    int checks = 0;
    int fails = 0;
    bit done_flag = 0;
    int cyc = 0;
    int lat = 3;
    int xsh = 0;
    int ysh = 0;
    int pen_mode = 0;
    int tcur = 16;
    int per = 0;
    int last_start = -1;
    int start_cnt = 0;
    bit expect_x = 1;
    logic [31:0] exp_q[$];

    tsq_scan_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .adc_power(adc_power), .adc_start(adc_start),
        .adc_done(adc_done), .adc_data(adc_data), .drive_x(drive_x),
        .drive_y(drive_y), .touch_sense(touch_sense), .pen_down(pen_down)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    function automatic logic [31:0] exp_word(input bit pen_up, input logic [9:0] x,
                                             input logic [9:0] y, input int xs, input int ys);
        logic [9:0] xa, ya;
        xa = x << xs;
        ya = y << ys;
        exp_word = {pen_up, 5'b0, xa, 6'b0, ya};
    endfunction

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // Converter and pen model; also checks axis order, pulse width and pair period
    initial begin : responder
        bit pen_cur;
        logic [9:0] xv, yv, v;
        pen_cur = 1'b1;
        xv = '0; yv = '0;
        forever begin
            @(negedge clk);
            if (adc_start) begin
                start_cnt++;
                chk("R2 axis order", {30'b0, drive_x, drive_y}, {30'b0, expect_x, !expect_x});
                if (expect_x) begin
                    if (last_start >= 0) chk("R2 pair period", cyc - last_start, per);
                    last_start = cyc;
                    case (pen_mode)
                        0: pen_cur = 1'b1;
                        1: pen_cur = $urandom % 2;
                        default: pen_cur = 1'b0;
                    endcase
                    pen_down = pen_cur;
                    xv = 10'($urandom % (1 << (10 - xsh)));
                    v = xv;
                end else begin
                    yv = 10'($urandom % (1 << (10 - ysh)));
                    v = yv;
                end
                if (lat > 1) begin
                    @(negedge clk);
                    chk("R3 start width", {31'b0, adc_start}, 32'd0);
                    repeat (lat - 2) @(negedge clk);
                end
                adc_data = v; adc_done = 1'b1;
                @(negedge clk);
                adc_done = 1'b0;
                if (!expect_x) exp_q.push_back(exp_word(!pen_cur, xv, yv, xsh, ysh));
                expect_x = !expect_x;
            end
        end
    end

    // Touch window width monitor
    initial begin : sense_mon
        int run;
        run = 0;
        forever begin
            @(negedge clk);
            if (touch_sense) run++;
            else if (run > 0) begin
                chk("R2 touch width", run, tcur);
                run = 0;
            end
        end
    end

    task automatic drain_check(input int n);
        logic [31:0] v;
        int keep;
        keep = (n > 4) ? 4 : n;
        @(negedge clk);
        chk("R8 irq level", {31'b0, irq}, {31'b0, (n >= 4)});
        rd_reg(3'd1, v);
        chk("R7 R6 status", v, ((n > 4) ? 32'h100 : 32'h0) | ((n == 0) ? 32'h80 : 32'h0));
        for (int k = 0; k < keep; k++) begin
            rd_reg(3'd2, v);
            chk("R4 R5 R6 word", v, exp_q[k]);
        end
        rd_reg(3'd1, v);
        chk("R7 R6 drained status", v, 32'h80);
    endtask

    task automatic run_phase(input int s, input int sd, input int g, input int t, input int i,
                             input int l, input int xs, input int ys, input int pm,
                             input int pairs, input bit stop_touch);
        logic [31:0] ctl;
        int sc;
        wr_reg(3'd3, s); wr_reg(3'd4, sd); wr_reg(3'd5, g);
        wr_reg(3'd6, t); wr_reg(3'd7, i);
        lat = l; xsh = xs; ysh = ys; pen_mode = pm; tcur = t;
        per = 2 * s + 2 * l + g + t + i;
        exp_q.delete(); expect_x = 1; last_start = -1;
        ctl = 32'h4 | (32'(xs) << 7) | (32'(ys) << 4);
        wr_reg(3'd0, ctl | 32'h1);
        for (int k = 0; k < pairs; k++) begin
            do @(negedge clk); while (!touch_sense);
            if (!(stop_touch && k == pairs - 1)) begin
                do @(negedge clk); while (touch_sense);
            end
        end
        sc = start_cnt;
        wr_reg(3'd0, ctl);
        repeat (300) @(negedge clk);
        chk("R10 no start after stop", start_cnt, sc);
        chk("R10 drives low", {29'b0, drive_x, drive_y, touch_sense}, 32'd0);
        chk("R10 pair count", exp_q.size(), pairs);
        drain_check(pairs);
    endtask

    initial begin : watchdog
        repeat (WD_CYCLES) @(posedge clk);
        checks++; fails++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        summary();
    end

    initial begin : main
        logic [31:0] v;
        int n;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rd_reg(3'd0, v); chk("R1 ctrl", v, 32'd0);
        rd_reg(3'd1, v); chk("R1 status", v, 32'h80);
        rd_reg(3'd3, v); chk("R1 settle", v, 32'd2);
        rd_reg(3'd4, v); chk("R1 start delay", v, 32'd2);
        rd_reg(3'd5, v); chk("R1 gap", v, 32'd4);
        rd_reg(3'd6, v); chk("R1 touch", v, 32'd16);
        rd_reg(3'd7, v); chk("R1 idle", v, 32'd88);
        chk("R1 outputs", {27'b0, irq, adc_power, drive_x, drive_y, adc_start}, 32'd0);
        // R11 power bit
        wr_reg(3'd0, 32'h4);
        @(negedge clk);
        chk("R11 adc_power", {31'b0, adc_power}, 32'd1);
        rd_reg(3'd0, v); chk("R11 ctrl readback", v, 32'h4);
        wr_reg(3'd0, 32'h0);
        @(negedge clk);
        chk("R11 adc_power off", {31'b0, adc_power}, 32'd0);
        // R9 start delay
        wr_reg(3'd3, 3); wr_reg(3'd4, 7);
        lat = 2; expect_x = 1; last_start = -1; pen_mode = 0;
        wr_reg(3'd0, 32'h5);
        n = 0;
        do begin @(negedge clk); n++; end while (!adc_start && n < 100);
        chk("R9 first start", n, 11);
        wr_reg(3'd0, 32'h4);
        repeat (300) @(negedge clk);
        drain_check(0);
        // directed: defaults, fixed latency, pen down
        run_phase(2, 2, 4, 16, 88, 3, 0, 0, 0, 3, 0);
        // R7 overrun with pen up
        run_phase(2, 2, 4, 16, 88, 2, 0, 0, 2, 6, 0);
        run_phase(1, 1, 2, 5, 20, 1, 0, 0, 1, 5, 0);
        // R5 reduced resolution
        run_phase(3, 2, 3, 8, 30, 4, 2, 5, 1, 4, 0);
        // R10 stop inside the touch window
        run_phase(2, 2, 4, 16, 40, 3, 1, 0, 1, 2, 1);
        // constrained random
        for (int r = 0; r < 6; r++) begin
            run_phase(1 + $urandom % 5, 1 + $urandom % 4, 1 + $urandom % 6, 1 + $urandom % 20,
                      10 + $urandom % 31, 1 + $urandom % 5, $urandom % 8, $urandom % 8,
                      1, 1 + $urandom % 6, $urandom % 2);
        end
        summary();
    end
endmodule